// File: doc/BRIEF.md
# Constant-Rate Interval Counter with Match

This block keeps a 64-bit elapsed-time count that moves upward at a fixed fraction of a reference clock. A small prescaler turns the reference clock into a single-cycle advance pulse once every `div_ratio + 1` cycles. The counter advances only on that pulse. The block has no input tied to the execution clock or to power state, so frequency scaling and clock gating elsewhere cannot change its rate.

Software can load the counter and the compare value at any time, and can read both back. When the count first becomes equal to the compare value, a sticky event flag is raised. The flag stays high until software clears it. Downstream logic uses the flag as an elapsed-time notification.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset the count reads 0, the compare value reads all ones, the event flag reads 0, and the prescaler phase is 0.
- R2: With a ratio setting of N, the count rises by exactly one every N+1 reference cycles. With N = 0 it rises on every cycle.
- R3: A count load is visible after the next clock edge and replaces any advance in that cycle. It also restarts the prescaler, so the next advance comes N+1 cycles after the load edge.
- R4: The count wraps from all ones to zero and keeps running.
- R5: A compare-value load is readable after the next clock edge.
- R6: The event flag goes to 1 on the clock edge that follows the first cycle in which the count equals the compare value.
- R7: The event flag stays at 1 until `evt_clr` is pulsed. It reads 0 after that edge, and it is not raised again while the count and the compare value stay different.
- R8: The event fires once per entry into equality. If `evt_clr` is pulsed while the count still equals the compare value, the flag stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ratio | input | RATIO_W | Advance period minus one, in reference cycles |
| cnt_wr_en | input | 1 | Load the count |
| cnt_wr_data | input | CNT_W | Count load value |
| match_wr_en | input | 1 | Load the compare value |
| match_wr_data | input | CNT_W | Compare load value |
| evt_clr | input | 1 | Clear the event flag |
| cnt_value | output | CNT_W | Current count |
| match_value | output | CNT_W | Current compare value |
| evt_flag | output | 1 | Sticky elapsed-time event |

## Verification
The bench loads the count while the prescaler would also have advanced it. A design that let the advance win would read one higher than the loaded value, and one that kept the old prescaler phase would advance early.

With a slow ratio, the count stays equal to the compare value for several cycles while `evt_clr` is pulsed. A level-sensitive design would raise the flag again at once.

The bench also loads all ones to check the wrap, and it checks the cycle in which the flag rises. A design with an extra compare register would raise the flag one cycle late.

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter int CNT_W   = 64,
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] div_ratio,
  input  logic               cnt_wr_en,
  input  logic [CNT_W-1:0]   cnt_wr_data,
  input  logic               match_wr_en,
  input  logic [CNT_W-1:0]   match_wr_data,
  input  logic               evt_clr,
  output logic [CNT_W-1:0]   cnt_value,
  output logic [CNT_W-1:0]   match_value,
  output logic               evt_flag
);

  logic [RATIO_W-1:0] pre_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   match_q;
  logic               eq_q;
  logic               evt_q;

  // >= keeps the period bounded when the ratio is lowered mid-period
  wire tick = (pre_q >= div_ratio);
  wire eq   = (cnt_q == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      match_q <= '1;
      eq_q    <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (cnt_wr_en || tick) pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;

      if (cnt_wr_en) cnt_q <= cnt_wr_data;
      else if (tick) cnt_q <= cnt_q + 1'b1;

      if (match_wr_en) match_q <= match_wr_data;

      eq_q <= eq;

      if (eq && !eq_q) evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end

  assign cnt_value   = cnt_q;
  assign match_value = match_q;
  assign evt_flag    = evt_q;

endmodule

module interval_tick_timer_chk #(
  parameter int CNT_W   = 64,
  parameter int RATIO_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             match_wr_en,
  input logic [CNT_W-1:0] match_wr_data,
  input logic             evt_clr,
  input logic [CNT_W-1:0] cnt_value,
  input logic [CNT_W-1:0] match_value,
  input logic             evt_flag
);

  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> cnt_value == $past(cnt_wr_data));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> (cnt_value == $past(cnt_value) || cnt_value == $past(cnt_value) + 1'b1));

  // R5
  match_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_wr_en |=> match_value == $past(match_wr_data));

  // R6
  evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(cnt_value == match_value));

  // R7
  evt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_flag) |-> $past(evt_clr));

endmodule

bind interval_tick_timer interval_tick_timer_chk #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
  .match_wr_en(match_wr_en), .match_wr_data(match_wr_data), .evt_clr(evt_clr),
  .cnt_value(cnt_value), .match_value(match_value), .evt_flag(evt_flag)
);

// File: tb/interval_tick_timer_tb_top.sv
`timescale 1ns/1ps
module interval_tick_timer_tb_top;
  localparam int CNT_W = 64;
  localparam int RATIO_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RATIO_W-1:0] div_ratio = '0;
  logic cnt_wr_en = 1'b0, match_wr_en = 1'b0, evt_clr = 1'b0;
  logic [CNT_W-1:0] cnt_wr_data = '0, match_wr_data = '0;
  logic [CNT_W-1:0] cnt_value, match_value;
  logic evt_flag;

  always #4 clk = ~clk;

  interval_tick_timer #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .match_wr_en(match_wr_en), .match_wr_data(match_wr_data),
    .evt_clr(evt_clr), .cnt_value(cnt_value), .match_value(match_value),
    .evt_flag(evt_flag)
  );

  typedef struct {
    string          req;
    int             kind;
    logic [CNT_W-1:0] exp;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic push(string req, int kind, logic [CNT_W-1:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cnt(logic [CNT_W-1:0] v);
    cnt_wr_en = 1'b1; cnt_wr_data = v;
    step(1);
    cnt_wr_en = 1'b0;
  endtask

  // monitor: compare pending items just after each falling edge
  initial begin
    forever begin
      @(negedge clk); #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [CNT_W-1:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = cnt_value;
          1: act = match_value;
          default: act = {{(CNT_W-1){1'b0}}, evt_flag};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    push("R1", 0, '0); push("R1", 1, '1); push("R1", 2, 0);
    step(1);
    rst_n = 1'b1;

    // R3 load beats a same-cycle advance, R2 ratio 0 advances each cycle
    div_ratio = 0;
    load_cnt(64'd100);
    push("R3", 0, 64'd100);
    step(7);
    push("R2", 0, 64'd107);

    // R5 compare load, R6 event timing
    match_wr_en = 1'b1; match_wr_data = 64'd200;
    load_cnt(64'd195);
    match_wr_en = 1'b0;
    push("R5", 1, 64'd200);
    step(5);
    push("R6", 0, 64'd200); push("R6", 2, 0);
    step(1);
    push("R6", 2, 1);

    // R7 sticky then cleared, no refire
    step(3);
    push("R7", 2, 1);
    evt_clr = 1'b1; step(1); evt_clr = 1'b0;
    push("R7", 2, 0);
    step(2);
    push("R7", 2, 0);

    // R8 equality held across a clear with ratio 3
    div_ratio = 3;
    match_wr_en = 1'b1; match_wr_data = 64'd500;
    load_cnt(64'd500);
    match_wr_en = 1'b0;
    push("R8", 2, 0);
    step(1);
    push("R8", 2, 1);
    evt_clr = 1'b1; step(1); evt_clr = 1'b0;
    push("R8", 2, 0);
    step(1);
    push("R8", 2, 0); push("R8", 0, 64'd500);

    // R2/R3 ratio 3: advance every 4 cycles, phase restarts at the load
    load_cnt(64'd1000);
    step(3);
    push("R3", 0, 64'd1000);
    step(1);
    push("R2", 0, 64'd1001);
    step(4);
    push("R2", 0, 64'd1002);

    // R4 wrap
    div_ratio = 0;
    load_cnt('1);
    push("R4", 0, '1);
    step(1);
    push("R4", 0, '0);
    step(2);
    push("R4", 0, 64'd2);

    step(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule